// File: doc/BRIEF.md
# Prioritized Interrupt Vector Dispatcher

This block sits next to a small processor core and decides which interrupt the core should take next. It keeps a five-bit request flag register and a five-bit mask register, plus a master enable. Peripherals raise single-cycle pulses that set request flags, and the core can read back and overwrite both registers. A source counts as pending when both its flag and its mask bit are set.

At an instruction boundary, with the master enable on and no service in progress, the block raises a request toward the core together with the vector of the highest-priority pending source. When the core acknowledges, the block clears that source's flag and the master enable. It then marks a fixed service window of four cycles, during which it makes no new request. The core drives the disable, enable and return-from-interrupt commands that control the master enable. A separate wake output releases a halted core whenever any source is pending, even if the master enable is off. Stacking the program counter and fetching instructions are left to the core.

Top module: `intc_vec_dispatch`

## Requirements
- R1: After reset, both flag and mask readbacks, the master enable, `irq_req`, `svc_busy` and `wake` are all 0.
- R2: `irq_req` is 1 exactly when the master enable is 1, `at_boundary` is 1, `svc_busy` is 0, and `flag_rd & mask_rd` is nonzero.
- R3: Priority is fixed, with bit 0 highest and bit 4 lowest. Bit 0 is video blank, bit 1 is display status, bit 2 is timer overflow, bit 3 is serial and bit 4 is keypad. `irq_vector` equals 0x40 + 8 × (index of the lowest set pending bit), which gives 0x40, 0x48, 0x50, 0x58 or 0x60. It is 0 when nothing is pending.
- R4: An `irq_ack` seen while `irq_req` is 1 clears only the flag bit of the source being served and clears the master enable, one cycle later.
- R5: After an accepted acknowledge, `svc_busy` is 1 for exactly 4 cycles, and `irq_req` stays 0 during that time.
- R6: `cmd_di` clears the master enable. `cmd_ei` and `cmd_reti` set it. When commands coincide, an accepted acknowledge wins over all of them, and `cmd_di` wins over `cmd_ei` and `cmd_reti`.
- R7: `wake` is 1 when `core_halted` is 1 and any source is pending, whatever the state of the master enable. It is 0 when `core_halted` is 0.
- R8: A `periph_req` pulse sets its flag bit on the next cycle. For its own bit, it takes precedence over a `flag_wr` write made in the same cycle.
- R9: `flag_wr` loads `wr_data` into the flag register and `mask_wr` loads it into the mask register; the new value is visible on the readback port one cycle later.
- R10: An `irq_ack` seen while `irq_req` is 0 has no effect: the flags, the master enable and `svc_busy` all keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_req | input | 5 | Peripheral request pulses, one per source |
| flag_wr | input | 1 | Write strobe for the flag register |
| mask_wr | input | 1 | Write strobe for the mask register |
| wr_data | input | 5 | Write data shared by both registers |
| flag_rd | output | 5 | Flag register readback |
| mask_rd | output | 5 | Mask register readback |
| cmd_di | input | 1 | Disable command (clears master enable) |
| cmd_ei | input | 1 | Enable command (sets master enable) |
| cmd_reti | input | 1 | Return-from-interrupt command (sets master enable) |
| at_boundary | input | 1 | Core is at an instruction boundary |
| core_halted | input | 1 | Core is halted |
| irq_req | output | 1 | Dispatch request to the core |
| irq_vector | output | 16 | Vector of the highest-priority pending source |
| irq_ack | input | 1 | Core accepts the dispatch |
| svc_busy | output | 1 | Service window in progress |
| master_en | output | 1 | Master enable state |
| wake | output | 1 | Release request for a halted core |

## Verification
The vector and request outputs are combinational functions of the flag and mask registers, so any corrupted register bit shows up in the same cycle as a wrong vector, a wrong request or a wrong wake level. The bench sweeps every flag and mask pairing for this reason. A master enable stuck in the wrong state, or a service counter with the wrong length, shows up within one to five cycles of an acknowledge. It appears as a request that should not be there, or as a busy window of the wrong width. An acknowledge that clears the wrong flag is caught on the next readback, and also by the vector chosen in the following dispatch.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned SRC_N      = 5;
  localparam int unsigned VEC_WIDTH  = 16;
  localparam int unsigned VEC_ORIGIN = 'h40;
  localparam int unsigned VEC_PITCH  = 8;
  localparam int unsigned SVC_CYCLES = 4;
endpackage

// File: rtl/intc_src_regs.sv
module intc_src_regs #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] periph_req,
  input  logic         flag_wr,
  input  logic         mask_wr,
  input  logic [N-1:0] wr_data,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] mask_q
);

  logic [N-1:0] flag_d;
  logic [N-1:0] mask_d;

  // Next-state: write, then service clear, then peripheral set (highest).
  always_comb begin
    flag_d = flag_q;
    if (flag_wr) flag_d = wr_data;
    flag_d = flag_d & ~clr_mask;
    flag_d = flag_d | periph_req;
  end

  always_comb begin
    mask_d = mask_q;
    if (mask_wr) mask_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= mask_d;
  end

  AST_ONE_SERVICE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_mask)); // R4

  AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|periph_req) |=> ((flag_q & $past(periph_req)) == $past(periph_req))); // R8

  AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(wr_data))); // R9

endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
  parameter int unsigned N     = 5,
  parameter int unsigned VW    = 16,
  parameter int unsigned BASE  = 'h40,
  parameter int unsigned PITCH = 8
) (
  input  logic [N-1:0]  pend,
  output logic          any_pend,
  output logic [N-1:0]  grant,
  output logic [VW-1:0] vector
);

  // Lowest index wins: each grant bit needs all lower bits clear.
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_grant
      if (g == 0) begin : g_first
        assign grant[g] = pend[g];
      end else begin : g_rest
        assign grant[g] = pend[g] & ~(|pend[g-1:0]);
      end
    end
  endgenerate

  assign any_pend = |pend;

  always_comb begin
    vector = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) vector = vector | VW'(BASE + i * PITCH);
    end
  end

endmodule

// File: rtl/intc_master_ctrl.sv
module intc_master_ctrl #(
  parameter int unsigned SVC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_ok,
  input  logic cmd_di,
  input  logic cmd_ei,
  input  logic cmd_reti,
  output logic ime_q,
  output logic busy
);

  localparam int unsigned CW = $clog2(SVC + 1);

  logic          ime_d;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  // Precedence: accepted ack > disable > enable/return.
  always_comb begin
    ime_d = ime_q;
    if (ack_ok)                  ime_d = 1'b0;
    else if (cmd_di)             ime_d = 1'b0;
    else if (cmd_ei || cmd_reti) ime_d = 1'b1;
  end

  always_comb begin
    cnt_en = ack_ok || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (ack_ok)             cnt_d = CW'(SVC);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ime_q <= 1'b0;
    else        ime_q <= ime_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  AST_ACK_DROPS_IME: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ok |=> !ime_q); // R6

  AST_ACK_STARTS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ok |=> busy); // R5

  AST_ENABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_ei || cmd_reti) && !cmd_di && !ack_ok) |=> ime_q); // R6

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_di |=> !ime_q); // R6

endmodule

// File: rtl/intc_vec_dispatch.sv
module intc_vec_dispatch
  import intc_pkg::*;
#(
  parameter int unsigned N     = SRC_N,
  parameter int unsigned VW    = VEC_WIDTH,
  parameter int unsigned BASE  = VEC_ORIGIN,
  parameter int unsigned PITCH = VEC_PITCH,
  parameter int unsigned SVC   = SVC_CYCLES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  periph_req,
  input  logic          flag_wr,
  input  logic          mask_wr,
  input  logic [N-1:0]  wr_data,
  output logic [N-1:0]  flag_rd,
  output logic [N-1:0]  mask_rd,
  input  logic          cmd_di,
  input  logic          cmd_ei,
  input  logic          cmd_reti,
  input  logic          at_boundary,
  input  logic          core_halted,
  output logic          irq_req,
  output logic [VW-1:0] irq_vector,
  input  logic          irq_ack,
  output logic          svc_busy,
  output logic          master_en,
  output logic          wake
);

  logic [N-1:0] flag_q;
  logic [N-1:0] mask_q;
  logic [N-1:0] pend;
  logic [N-1:0] grant;
  logic [N-1:0] clr_mask;
  logic         any_pend;
  logic         ime_q;
  logic         busy;
  logic         ack_ok;

  intc_src_regs #(.N(N)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .periph_req (periph_req),
    .flag_wr    (flag_wr),
    .mask_wr    (mask_wr),
    .wr_data    (wr_data),
    .clr_mask   (clr_mask),
    .flag_q     (flag_q),
    .mask_q     (mask_q)
  );

  assign pend = flag_q & mask_q;

  intc_prio_pick #(.N(N), .VW(VW), .BASE(BASE), .PITCH(PITCH)) u_pick (
    .pend     (pend),
    .any_pend (any_pend),
    .grant    (grant),
    .vector   (irq_vector)
  );

  assign irq_req  = ime_q & at_boundary & ~busy & any_pend;
  assign ack_ok   = irq_ack & irq_req;
  assign clr_mask = ack_ok ? grant : '0;

  intc_master_ctrl #(.SVC(SVC)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_ok   (ack_ok),
    .cmd_di   (cmd_di),
    .cmd_ei   (cmd_ei),
    .cmd_reti (cmd_reti),
    .ime_q    (ime_q),
    .busy     (busy)
  );

  assign flag_rd   = flag_q;
  assign mask_rd   = mask_q;
  assign svc_busy  = busy;
  assign master_en = ime_q;
  assign wake      = core_halted & any_pend;

  AST_NO_REQ_IN_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    svc_busy |-> !irq_req); // R5

  AST_IGNORED_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_req && !flag_wr && (periph_req == '0)) |=> (flag_rd == $past(flag_rd))); // R10

  AST_ACK_CLEARS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ok && !flag_wr && ((periph_req & grant) == '0)) |=> ((flag_rd & $past(grant)) == '0)); // R4

endmodule

// File: tb/intc_vec_dispatch_tb.sv
`timescale 1ns/1ps
module intc_vec_dispatch_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  periph_req;
  logic        flag_wr, mask_wr;
  logic [4:0]  wr_data;
  logic [4:0]  flag_rd, mask_rd;
  logic        cmd_di, cmd_ei, cmd_reti;
  logic        at_boundary, core_halted;
  logic        irq_req;
  logic [15:0] irq_vector;
  logic        irq_ack;
  logic        svc_busy, master_en, wake;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  intc_vec_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .periph_req(periph_req),
    .flag_wr(flag_wr), .mask_wr(mask_wr), .wr_data(wr_data),
    .flag_rd(flag_rd), .mask_rd(mask_rd),
    .cmd_di(cmd_di), .cmd_ei(cmd_ei), .cmd_reti(cmd_reti),
    .at_boundary(at_boundary), .core_halted(core_halted),
    .irq_req(irq_req), .irq_vector(irq_vector), .irq_ack(irq_ack),
    .svc_busy(svc_busy), .master_en(master_en), .wake(wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_vec(input logic [4:0] p);
    for (int i = 0; i < 5; i++) if (p[i]) return 16'(16'h40 + 8 * i);
    return 16'h0;
  endfunction

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    periph_req = '0; flag_wr = 0; mask_wr = 0; wr_data = '0;
    cmd_di = 0; cmd_ei = 0; cmd_reti = 0; irq_ack = 0;
  endtask

  task automatic load(input logic [4:0] f, input logic [4:0] m);
    flag_wr = 1; wr_data = f; step();
    flag_wr = 0; mask_wr = 1; wr_data = m; step();
    mask_wr = 0; step();
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle_inputs(); at_boundary = 1; core_halted = 0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 flag", flag_rd, 0);   chk("R1 mask", mask_rd, 0);
    chk("R1 ime", master_en, 0);  chk("R1 req", irq_req, 0);
    chk("R1 busy", svc_busy, 0);  chk("R1 wake", wake, 0);
    @(negedge clk); rst_n = 1; step();

    // R2 no request while master enable off
    load(5'h1f, 5'h1f);
    chk("R2 req with ime=0", irq_req, 0);
    // R7 wake with ime off
    core_halted = 1; #1;
    chk("R7 wake ime=0", wake, 1);
    core_halted = 0; #1;
    chk("R7 no wake when running", wake, 0);

    // R6 enable via ei
    cmd_ei = 1; step(); cmd_ei = 0;
    chk("R6 ei sets", master_en, 1);

    // R2/R3/R7/R9 sweep of all flag/mask pairs
    core_halted = 1;
    for (int f = 0; f < 32; f++) begin
      for (int m = 0; m < 32; m++) begin
        logic [4:0] p;
        load(5'(f), 5'(m));
        p = 5'(f) & 5'(m);
        chk("R9 flag readback", flag_rd, 32'(f));
        chk("R9 mask readback", mask_rd, 32'(m));
        chk("R2 req", irq_req, 32'(p != 0));
        chk("R3 vector", irq_vector, 32'(exp_vec(p)));
        chk("R7 wake", wake, 32'(p != 0));
      end
    end
    core_halted = 0;

    // R2 boundary gating
    load(5'b00100, 5'h1f);
    at_boundary = 0; #1;
    chk("R2 off boundary", irq_req, 0);
    at_boundary = 1; #1;
    chk("R2 at boundary", irq_req, 1);

    // R4/R5 acknowledge and service window
    load(5'b10110, 5'h1f);
    chk("R3 vec 0x48", irq_vector, 16'h48);
    irq_ack = 1; step(); irq_ack = 0;
    chk("R4 flag after ack", flag_rd, 5'b10100);
    chk("R4 ime after ack", master_en, 0);
    chk("R5 busy c1", svc_busy, 1);
    cmd_ei = 1; step(); cmd_ei = 0;
    chk("R5 busy c2", svc_busy, 1);
    chk("R5 no req in svc", irq_req, 0);
    step(); chk("R5 busy c3", svc_busy, 1);
    step(); chk("R5 busy c4", svc_busy, 1);
    chk("R5 no req c4", irq_req, 0);
    step(); chk("R5 busy end", svc_busy, 0);
    chk("R2 req after svc", irq_req, 1);
    chk("R3 next vec 0x50", irq_vector, 16'h50);

    // R6 ack beats ei in same cycle
    irq_ack = 1; cmd_ei = 1; step(); irq_ack = 0; cmd_ei = 0;
    chk("R6 ack over ei", master_en, 0);
    chk("R4 flag second ack", flag_rd, 5'b10000);
    repeat (4) step();

    // R6 reti sets, di beats ei
    cmd_reti = 1; step(); cmd_reti = 0;
    chk("R6 reti sets", master_en, 1);
    cmd_di = 1; cmd_ei = 1; step(); cmd_di = 0; cmd_ei = 0;
    chk("R6 di over ei", master_en, 0);

    // R10 ack ignored without request
    irq_ack = 1; step(); irq_ack = 0;
    chk("R10 flag kept", flag_rd, 5'b10000);
    chk("R10 busy idle", svc_busy, 0);
    chk("R10 ime kept", master_en, 0);

    // R8 peripheral pulse and precedence over write
    flag_wr = 1; wr_data = 5'b00011; periph_req = 5'b00100; step();
    flag_wr = 0; periph_req = 0;
    chk("R8 pulse beats write", flag_rd, 5'b00111);
    flag_wr = 1; wr_data = 5'b00000; periph_req = 5'b01000; step();
    flag_wr = 0; periph_req = 0;
    chk("R8 pulse over clear", flag_rd, 5'b01000);
    periph_req = 5'b00001; step(); periph_req = 0;
    chk("R8 pulse sets", flag_rd, 5'b01001);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule